// File: doc/BRIEF.md
# CAS-Latency Read Capture Pipeline

This block sits on the controller side of a synchronous DRAM read path. It watches the command stream the sequencer drives to the memory. For each read burst it works out on which clock edge every returned 16-bit word is present on the data bus. It captures that word, marks it valid and tags it with its position in the burst. The CAS latency (2 or 3 clocks) and the burst length are taken from the command edge of each read, so a later change to the settings leaves a burst that is already in flight alone.

A read can carry a request for fewer words than the programmed burst. The block then tells the sequencer, through a one-cycle strobe, the exact cycle in which a burst stop or a precharge must be issued so that the burst ends right after the last wanted word. It refuses such a request when it cannot be honoured. The block also reacts to the commands that really end or replace a burst: a burst stop, a precharge of the bank being read, a precharge of all banks, and a new read. In each case it drops exactly the beats that the memory will no longer drive.

Top module: `rcp_read_capture`

## Requirements
- R1: A read registered at edge n is captured from `dq_i` at edge n+CL, with CL = 3 when `cl3_i` = 1 and CL = 2 when it is 0. From that edge on, `rdata_valid_o` and `rdata_o` show the captured word.
- R2: After the first word, one word is captured on each edge. `beat_o` counts 0,1,2,… The word count follows `bl_i`: 0→1, 1→2, 2→4, 3→8, 7→page of 512. Codes 4–6 give one word.
- R3: A page burst (`bl_i` = 7) keeps going past beat 511. Its beat index wraps to 0 and the burst continues until a burst stop or a matching precharge ends it.
- R4: The latency and length in force are the ones present at the read's edge. Changing `cl3_i` or `bl_i` during a burst has no effect on the capture timing, the data or the beat indices.
- R5: A new read at edge t2 takes over. Beats of the older burst due at edge t2+CL or later are dropped, and the new burst's beat 0 lands at t2+CL, with no gap and no lost word.
- R6: A burst stop (`cmd_i` = 4), or a precharge (`cmd_i` = 3) either with `all_i` = 1 or with `bank_i` equal to the read's bank, registered at edge t ends the burst. The last captured word is the one at edge t+CL−1.
- R7: A precharge with `all_i` = 0 to a bank other than the one being read has no effect on the burst.
- R8: For a plain read (`cmd_i` = 1) with `trunc_req_i` = 1 and a word count W, the request is accepted when 1 ≤ W < burst length, or 1 ≤ W ≤ 512 for a page burst. `term_ok_o` is then high for exactly the one cycle that precedes edge n+W.
- R9: A truncation request on a read with auto precharge (`cmd_i` = 2), or one with W = 0, or one with W not below the burst length (for a non-page burst), is refused. `trunc_rej_o` pulses for the one cycle after edge n and `term_ok_o` stays low for that burst.
- R10: While `rst` is high, `rdata_valid_o`, `term_ok_o` and `trunc_rej_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all edges rising |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command this cycle: 0 none, 1 read, 2 read with auto precharge, 3 precharge, 4 burst stop |
| bank_i | input | 2 | Bank of the read or precharge |
| all_i | input | 1 | Precharge applies to all banks |
| cl3_i | input | 1 | CAS latency select: 1 = three clocks, 0 = two |
| bl_i | input | 3 | Burst length code |
| trunc_req_i | input | 1 | Truncation wanted for this read |
| trunc_words_i | input | 10 | Number of words wanted |
| dq_i | input | 16 | Data bus from the memory |
| rdata_valid_o | output | 1 | Captured word valid |
| rdata_o | output | 16 | Captured word |
| beat_o | output | 9 | Beat index of the captured word |
| term_ok_o | output | 1 | Issue burst stop or precharge in this cycle |
| trunc_rej_o | output | 1 | Truncation request refused |

## Verification
Two events can fall on the same edge. The first is the capture of older beats that are still in the latency pipeline. The second is a command that ends or replaces the burst, such as a stop, a precharge or a new read. The bench provokes this by interrupting an eight-word burst at every offset from one to eight cycles. It also truncates at every legal word count, including W = 1, where the stop arrives while beat 0 is still in flight. Each captured edge is compared with a window computed from CL, the command edges and the word count: validity, beat index and data must all match, and any extra or missing word is reported.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int PAGE_WORDS = 512;
    localparam int BEAT_W     = $clog2(PAGE_WORDS);
    localparam int LEN_W      = BEAT_W + 1;
    localparam int CL_MAX     = 3;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_RD  = 3'd1,
        CMD_RDA = 3'd2,
        CMD_PRE = 3'd3,
        CMD_BST = 3'd4
    } cmd_e;

    localparam logic [2:0] BL_PAGE = 3'd7;

    typedef logic [BEAT_W-1:0] beat_t;

    // One beat travelling towards the data bus
    typedef struct packed {
        logic  vld;
        logic  lat3;
        beat_t beat;
    } tag_t;

    function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return LEN_W'(1);
            3'd1:    return LEN_W'(2);
            3'd2:    return LEN_W'(4);
            3'd3:    return LEN_W'(8);
            3'd7:    return LEN_W'(PAGE_WORDS);
            default: return LEN_W'(1);
        endcase
    endfunction

    function automatic logic is_read(input logic [2:0] c);
        return (c == CMD_RD) || (c == CMD_RDA);
    endfunction

endpackage

// File: rtl/rcp_burst_gen.sv
module rcp_burst_gen
    import rcp_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic              cl3_i,
    input  logic [2:0]        bl_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              all_i,
    input  logic              trunc_req_i,
    input  logic [LEN_W-1:0]  trunc_words_i,
    output tag_t              gen_o,
    output logic              term_ok_o,
    output logic              trunc_rej_o
);

    tag_t              gen_q;
    beat_t             last_q;
    beat_t             tgt_q;
    logic              full_q;
    logic              armed_q;
    logic              rej_q;
    logic [BANK_W-1:0] bank_q;

    logic             rd_hit;
    logic             stop_hit;
    logic             full_n;
    logic             accept;
    logic [LEN_W-1:0] len_n;

    always_comb begin
        rd_hit   = is_read(cmd_i);
        len_n    = burst_words(bl_i);
        full_n   = (bl_i == BL_PAGE);
        accept   = trunc_req_i && (cmd_i == CMD_RD) && (trunc_words_i != '0) &&
                   (full_n ? (trunc_words_i <= LEN_W'(PAGE_WORDS)) : (trunc_words_i < len_n));
        stop_hit = (cmd_i == CMD_BST) ||
                   ((cmd_i == CMD_PRE) && (all_i || (bank_i == bank_q)));
    end

    // Beat issue runs CL cycles ahead of the bus
    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q   <= '0;
            last_q  <= '0;
            tgt_q   <= '0;
            full_q  <= 1'b0;
            armed_q <= 1'b0;
            rej_q   <= 1'b0;
            bank_q  <= '0;
        end else begin
            rej_q <= 1'b0;
            if (rd_hit) begin
                gen_q.vld  <= 1'b1;
                gen_q.lat3 <= cl3_i;
                gen_q.beat <= '0;
                last_q     <= BEAT_W'(len_n - LEN_W'(1));
                full_q     <= full_n;
                bank_q     <= bank_i;
                armed_q    <= accept;
                tgt_q      <= BEAT_W'(trunc_words_i - LEN_W'(1));
                rej_q      <= trunc_req_i && !accept;
            end else if (stop_hit) begin
                gen_q.vld <= 1'b0;
                armed_q   <= 1'b0;
            end else if (gen_q.vld) begin
                if (full_q || (gen_q.beat != last_q)) begin
                    gen_q.beat <= gen_q.beat + 1'b1;
                end else begin
                    gen_q.vld <= 1'b0;
                    armed_q   <= 1'b0;
                end
            end
        end
    end

    assign gen_o       = gen_q;
    assign term_ok_o   = gen_q.vld && armed_q && (gen_q.beat == tgt_q);
    assign trunc_rej_o = rej_q;

endmodule

// File: rtl/rcp_lat_pipe.sv
module rcp_lat_pipe
    import rcp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tag_t              gen_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o,
    output beat_t             beat_o
);

    localparam int NSTG = CL_MAX - 1;

    // stg_q[s] holds a beat issued s+1 cycles ago; latency s+2 takes it
    tag_t            stg_q [NSTG];
    logic [NSTG-1:0] hit;
    int              sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSTG; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= gen_i;
            for (int s = 1; s < NSTG; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_tap
        assign hit[s] = stg_q[s].vld && (stg_q[s].lat3 == ((s + 2) == 3));
    end

    always_comb begin
        sel = 0;
        for (int s = NSTG - 1; s >= 0; s--) begin
            if (hit[s]) sel = s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
            beat_o <= '0;
        end else begin
            vld_o <= |hit;
            if (|hit) begin
                data_o <= dq_i;
                beat_o <= stg_q[sel].beat;
            end
        end
    end

endmodule

// File: rtl/rcp_read_capture.sv
module rcp_read_capture
    import rcp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              all_i,
    input  logic              cl3_i,
    input  logic [2:0]        bl_i,
    input  logic              trunc_req_i,
    input  logic [LEN_W-1:0]  trunc_words_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rdata_valid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              term_ok_o,
    output logic              trunc_rej_o
);

    tag_t gen;

    rcp_burst_gen #(.BANK_W(BANK_W)) u_gen (
        .clk           (clk),
        .rst           (rst),
        .cmd_i         (cmd_i),
        .cl3_i         (cl3_i),
        .bl_i          (bl_i),
        .bank_i        (bank_i),
        .all_i         (all_i),
        .trunc_req_i   (trunc_req_i),
        .trunc_words_i (trunc_words_i),
        .gen_o         (gen),
        .term_ok_o     (term_ok_o),
        .trunc_rej_o   (trunc_rej_o)
    );

    rcp_lat_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .gen_i  (gen),
        .dq_i   (dq_i),
        .vld_o  (rdata_valid_o),
        .data_o (rdata_o),
        .beat_o (beat_o)
    );

endmodule

// File: rtl/rcp_read_capture_chk.sv
module rcp_read_capture_chk
    import rcp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_i,
    input logic              rdata_valid_o,
    input logic [BEAT_W-1:0] beat_o,
    input logic              term_ok_o,
    input logic              trunc_rej_o
);

    logic [2:0] up_q;

    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else if (up_q != 3'd7) up_q <= up_q + 3'd1;
    end

    // R1: a fresh burst starts at beat 0, CL+1 sample edges after a read
    a_r1_first_after_read: assert property (@(posedge clk) disable iff (rst)
        (up_q >= 3'd5) && $rose(rdata_valid_o) |->
            (beat_o == '0) && (is_read($past(cmd_i, 3)) || is_read($past(cmd_i, 4))));

    // R2 / R3: consecutive words either restart or step by one (wrapping)
    a_r2_beat_step: assert property (@(posedge clk) disable iff (rst)
        (up_q >= 3'd2) && rdata_valid_o && $past(rdata_valid_o) |->
            (beat_o == '0) || (beat_o == BEAT_W'($past(beat_o) + 1'b1)));

    // R6: nothing is captured three edges after a stop with no read following
    a_r6_stop_drains: assert property (@(posedge clk) disable iff (rst)
        (up_q >= 3'd5) && ($past(cmd_i, 4) == CMD_BST) &&
        !is_read($past(cmd_i, 3)) && !is_read($past(cmd_i, 2)) |-> !rdata_valid_o);

    // R8: the strobe lasts one cycle unless a new read rearms it
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        term_ok_o |=> !term_ok_o || is_read($past(cmd_i)));

    // R9: a refused request never comes with a strobe
    a_r9_reject_no_strobe: assert property (@(posedge clk) disable iff (rst)
        trunc_rej_o |-> !term_ok_o);

endmodule

bind rcp_read_capture rcp_read_capture_chk u_chk (.*);

// File: tb/rcp_read_capture_tb.sv
module rcp_read_capture_tb;
    import rcp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = '0;
    logic [1:0]  bank_i = '0;
    logic        all_i = 1'b0;
    logic        cl3_i = 1'b0;
    logic [2:0]  bl_i = '0;
    logic        trunc_req_i = 1'b0;
    logic [9:0]  trunc_words_i = '0;
    logic [15:0] dq_i = '0;
    logic        rdata_valid_o;
    logic [15:0] rdata_o;
    logic [8:0]  beat_o;
    logic        term_ok_o;
    logic        trunc_rej_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rcp_read_capture u_dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .all_i(all_i),
        .cl3_i(cl3_i), .bl_i(bl_i), .trunc_req_i(trunc_req_i),
        .trunc_words_i(trunc_words_i), .dq_i(dq_i),
        .rdata_valid_o(rdata_valid_o), .rdata_o(rdata_o), .beat_o(beat_o),
        .term_ok_o(term_ok_o), .trunc_rej_o(trunc_rej_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int e, input int s);
        return 16'(e * 40503 + s * 773 + 17);
    endfunction

    function automatic int words(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 512;
            default: return 1;
        endcase
    endfunction

    // tkind: 0 none, 1 precharge, 2 burst stop
    task automatic run_read(input bit cl3, input int blc, input bit treq, input int w,
                            input bit ap, input int bank, input int tat, input int tkind,
                            input int tbank, input bit tall, input int seed);
        int m, L, cnt, last_e;
        bit full, accept, eff, expv, expt;
        string rq;
        m      = cl3 ? 3 : 2;
        L      = words(blc);
        full   = (blc == 7);
        accept = treq && !ap && (w != 0) && (full ? (w <= 512) : (w < L));
        eff    = (tkind == 2) || ((tkind == 1) && (tall || (tbank == bank)));
        cnt    = L;
        if (eff && (full || tat < L)) cnt = tat;
        last_e = m + cnt + 2;
        if (tkind != 0 && tat + 2 > last_e) last_e = tat + 2;
        if (full) rq = "R3";
        else if (tkind == 1 && !eff) rq = "R7";
        else if (eff && cnt < L) rq = "R6";
        else rq = "R1";
        for (int e = 0; e <= last_e; e++) begin
            if (e >= 1) begin
                expt = accept && (e == w);
                chk(term_ok_o === expt, "R8 term_ok", int'(term_ok_o), int'(expt));
                if (e == 1)
                    chk(trunc_rej_o === (treq && !accept), "R9 reject", int'(trunc_rej_o),
                        int'(treq && !accept));
                else
                    chk(trunc_rej_o === 1'b0, "R9 reject idle", int'(trunc_rej_o), 0);
            end
            if (e == 0) cmd_i = ap ? 3'd2 : 3'd1;
            else if (tkind != 0 && e == tat) cmd_i = (tkind == 1) ? 3'd3 : 3'd4;
            else cmd_i = 3'd0;
            bank_i        = (e == 0) ? 2'(bank) : 2'(tbank);
            all_i         = (e == tat) && tall;
            cl3_i         = (e == 0) ? cl3 : !cl3;
            bl_i          = (e == 0) ? 3'(blc) : 3'd0;
            trunc_req_i   = (e == 0) && treq;
            trunc_words_i = 10'(w);
            dq_i          = pat(e, seed);
            @(posedge clk);
            @(negedge clk);
            expv = (e >= m) && (e < m + cnt);
            chk(rdata_valid_o === expv, rq, int'(rdata_valid_o), int'(expv));
            if (expv) begin
                chk(beat_o === 9'((e - m) % 512), "R2 beat", int'(beat_o), (e - m) % 512);
                chk(rdata_o === pat(e, seed), "R4 data", int'(rdata_o), int'(pat(e, seed)));
            end
        end
        cmd_i = 3'd0;
        all_i = 1'b0;
        trunc_req_i = 1'b0;
    endtask

    // Eight-word read at edge 0, four-word read at edge t2
    task automatic run_intr(input bit cl3, input int t2, input int seed);
        int m, expb;
        bit expv;
        m = cl3 ? 3 : 2;
        for (int e = 0; e <= t2 + m + 6; e++) begin
            if (e >= 1) chk(term_ok_o === 1'b0, "R8 no strobe", int'(term_ok_o), 0);
            cmd_i       = (e == 0 || e == t2) ? 3'd1 : 3'd0;
            bl_i        = (e == 0) ? 3'd3 : 3'd2;
            cl3_i       = cl3;
            bank_i      = 2'd0;
            trunc_req_i = 1'b0;
            dq_i        = pat(e, seed);
            @(posedge clk);
            @(negedge clk);
            expv = 1'b0;
            expb = 0;
            if (e >= t2 + m && e < t2 + m + 4) begin
                expv = 1'b1;
                expb = e - t2 - m;
            end else if (e >= m && e < m + 8 && e < t2 + m) begin
                expv = 1'b1;
                expb = e - m;
            end
            chk(rdata_valid_o === expv, "R5 valid", int'(rdata_valid_o), int'(expv));
            if (expv) begin
                chk(beat_o === 9'(expb), "R5 beat", int'(beat_o), expb);
                chk(rdata_o === pat(e, seed), "R5 data", int'(rdata_o), int'(pat(e, seed)));
            end
        end
        cmd_i = 3'd0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int codes [5];
        int seed;
        codes = '{0, 1, 2, 3, 7};
        seed  = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(rdata_valid_o === 1'b0, "R10 valid", int'(rdata_valid_o), 0);
        chk(term_ok_o === 1'b0, "R10 term_ok", int'(term_ok_o), 0);
        chk(trunc_rej_o === 1'b0, "R10 reject", int'(trunc_rej_o), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int cl = 0; cl < 2; cl++) begin
            for (int bi = 0; bi < 5; bi++) begin
                int blc, L, wmax;
                bit full;
                blc  = codes[bi];
                L    = words(blc);
                full = (blc == 7);
                if (full) run_read(cl[0], blc, 0, 0, 0, 1, 515, 2, 0, 0, seed++);
                else      run_read(cl[0], blc, 0, 0, 0, 1, 0, 0, 0, 0, seed++);
                wmax = full ? 3 : L;
                for (int w = 0; w <= wmax; w++) begin
                    bit acc;
                    acc = (w != 0) && (full || w < L);
                    if (acc) run_read(cl[0], blc, 1, w, 0, 2, w, (w % 2 == 1) ? 1 : 2, 2, 0, seed++);
                    else if (full) run_read(cl[0], blc, 1, w, 0, 2, 20, 2, 0, 0, seed++);
                    else run_read(cl[0], blc, 1, w, 0, 2, 0, 0, 0, 0, seed++);
                end
                if (full) begin
                    run_read(cl[0], blc, 1, 512, 0, 0, 512, 1, 0, 0, seed++);
                    run_read(cl[0], blc, 1, 4, 1, 0, 12, 2, 0, 0, seed++);
                end else begin
                    run_read(cl[0], blc, 1, 1, 1, 0, 0, 0, 0, 0, seed++);
                end
                if (!full && L >= 4) begin
                    run_read(cl[0], blc, 0, 0, 0, 1, 1, 1, 2, 0, seed++);
                    run_read(cl[0], blc, 0, 0, 0, 1, 2, 1, 3, 1, seed++);
                end
            end
            for (int t2 = 1; t2 <= 8; t2++) run_intr(cl[0], t2, seed++);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule